// File: doc/BRIEF.md
# Video Frame Resolution Match Checker

This block watches one incoming pixel stream and decides whether the frames on it have the resolution that configuration expects. For every field it counts the pixels in each line and the number of completed lines. When the field closes, it compares those counts against a programmed active width and a per-field height. The result is a single status flag that is high only while the most recently measured frame agrees with the programmed resolution. A system with several virtual-channel streams places one instance per stream.

The stream carries a valid qualifier, a start-of-frame marker on the first pixel of a field, an end-of-line marker on the last pixel of each line, and a field identifier. In progressive mode only start-of-frame closes a field. The field identifier is ignored, and the field-0 height is the only height used. In interlaced mode a change of field identifier also closes a field. Each field is then checked against its own height, and the flag is raised only when both the latest field 0 and the latest field 1 matched. Configuration arrives as plain input ports. Any change to them discards the measurement in progress and clears the flag.

`rst_n` is asserted asynchronously and must be released synchronously to `clk` outside this block.

Top module: `vrc_res_check`

## Requirements
- R1: After reset `match_o` is 0, and it stays 0 until a complete field has been measured and found to match.
- R2: Progressive mode (`cfg_interlaced`=0). A field matches when every line holds exactly `cfg_width` pixels and the line count equals `cfg_height0`. `in_field` and `cfg_height1` have no effect in this mode. The field closes at the next valid beat carrying `in_sof`. `match_o` takes the result on the second rising clock edge after that beat is sampled, and then holds it until the next result.
- R3: A field in which any line ends (valid beat with `in_eol`=1) after more or fewer than `cfg_width` pixels is a mismatch.
- R4: A field is a mismatch if its line count differs from the selected height, or if it ends with pixels after the last `in_eol` (an unfinished line).
- R5: A field starts on a valid beat with `in_sof`=1, or, in interlaced mode only, on a valid beat whose `in_field` differs from the field currently open. That beat is the first pixel of the new field. Valid beats arriving while no field is open and without `in_sof` are ignored.
- R6: Interlaced mode (`cfg_interlaced`=1). A field with `in_field`=0 is checked against `cfg_height0`, and a field with `in_field`=1 against `cfg_height1`. When a field closes as a match, `match_o` becomes 1 only if the latest field of the other identifier also matched. A mismatching field clears `match_o`, and that field identifier must match again before the flag can return.
- R7: If any of `cfg_width`, `cfg_height0`, `cfg_height1` or `cfg_interlaced` differs from its value on the previous clock, `match_o` is 0 after that edge. The field in progress and any pending result are discarded, the history of both fields is cleared, and measuring restarts at the next `in_sof`.
- R8: The pixel and line counters saturate at 2^16-1 and flag an overflow. A line of more than 65535 pixels therefore never matches: a 65537-pixel line against `cfg_width`=1 is a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | Pixel beat qualifier |
| in_sof | input | 1 | First pixel of a field (with in_valid) |
| in_eol | input | 1 | Last pixel of a line (with in_valid) |
| in_field | input | 1 | Field identifier of the beat |
| cfg_width | input | 16 | Expected active pixels per line |
| cfg_height0 | input | 16 | Expected lines, progressive frame or field 0 |
| cfg_height1 | input | 16 | Expected lines, field 1 when interlaced |
| cfg_interlaced | input | 1 | 1 selects interlaced operation |
| match_o | output | 1 | Latest frame matched the programmed resolution |

## Verification
The bench sends lines that are one pixel short or long in the middle of a field, fields with one line too many or too few, and a field ending in an unfinished line. A design that checked only the last line, or that counted a partial line as complete, would raise the flag on these. In interlaced mode it sends a field 1 sized to the field-0 height, a bad field followed by a good field of the other identifier, and recovery sequences. A design that shared one height between fields, or that kept stale history, would report a match too early. It changes configuration in the middle of a field, toggles the field identifier in progressive mode, and sends a 65537-pixel line that a wrapping 16-bit counter would take for a one-pixel line.

// File: rtl/vrc_pkg.sv
package vrc_pkg;

  // Scan type selected by the configuration input
  typedef enum logic {
    SCAN_PROG = 1'b0,
    SCAN_INTL = 1'b1
  } scan_e;

  // Verdict for one closed field
  typedef struct packed {
    logic ok;
    logic fid;
  } fres_t;

endpackage

// File: rtl/vrc_cfg_watch.sv
module vrc_cfg_watch #(
  parameter int unsigned DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM_W-1:0] cfg_width,
  input  logic [DIM_W-1:0] cfg_height0,
  input  logic [DIM_W-1:0] cfg_height1,
  input  logic             cfg_interlaced,
  output logic             cfg_chg
);

  localparam int unsigned CFG_W = 3 * DIM_W + 1;

  logic [CFG_W-1:0] cfg_now;
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;
  logic             primed_q;
  logic             primed_d;

  assign cfg_now = {cfg_interlaced, cfg_height1, cfg_height0, cfg_width};

  // Next state: remember the configuration seen this cycle
  always_comb begin
    cfg_d    = cfg_now;
    primed_d = 1'b1;
    cfg_chg  = primed_q && (cfg_now != cfg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      primed_q <= primed_d;
    end
  end

endmodule

// File: rtl/vrc_line_meter.sv
module vrc_line_meter #(
  parameter int unsigned DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             start,
  input  logic             in_eol,
  input  logic [DIM_W-1:0] cfg_width,
  output logic             pix_pend,
  output logic             line_err
);

  localparam logic [DIM_W-1:0] CNT_MAX = '1;

  logic [DIM_W-1:0] pix_q;
  logic [DIM_W-1:0] pix_d;
  logic [DIM_W-1:0] pix_base;
  logic [DIM_W-1:0] pix_now;
  logic             err_q;
  logic             err_d;
  logic             err_base;
  logic             at_max;

  // Next state for the pixels-in-line counter and the sticky width error
  always_comb begin
    pix_base = start ? '0 : pix_q;
    err_base = start ? 1'b0 : err_q;
    at_max   = (pix_base == CNT_MAX);
    pix_now  = at_max ? CNT_MAX : pix_base + 1'b1;
    if (in_eol) begin
      pix_d = '0;
      err_d = err_base | at_max | (pix_now != cfg_width);
    end else begin
      pix_d = pix_now;
      err_d = err_base | at_max;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      err_q <= 1'b0;
    end else if (cnt_en) begin
      pix_q <= pix_d;
      err_q <= err_d;
    end
  end

  assign pix_pend = (pix_q != '0);
  assign line_err = err_q;

endmodule

// File: rtl/vrc_field_meter.sv
module vrc_field_meter
  import vrc_pkg::*;
#(
  parameter int unsigned DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic             in_field,
  input  logic             cfg_interlaced,
  input  logic [DIM_W-1:0] cfg_height0,
  input  logic [DIM_W-1:0] cfg_height1,
  input  logic             cfg_chg,
  input  logic             pix_pend,
  input  logic             line_err,
  output logic             start,
  output logic             cnt_en,
  output logic             res_vld,
  output fres_t            res
);

  localparam logic [DIM_W-1:0] CNT_MAX = '1;

  scan_e            mode;
  logic             active_q;
  logic             active_d;
  logic             fid_q;
  logic [DIM_W-1:0] line_q;
  logic [DIM_W-1:0] line_d;
  logic [DIM_W-1:0] line_base;
  logic             lovf_q;
  logic             lovf_d;
  logic             lovf_base;
  logic             fid_chg;
  logic             close;
  logic [DIM_W-1:0] h_sel;
  logic             fld_ok;
  logic             res_vld_q;
  logic             res_vld_d;
  fres_t            res_q;
  fres_t            res_d;

  assign mode = scan_e'(cfg_interlaced);

  // Next state: field boundaries, line count and verdict of the closing field
  always_comb begin
    fid_chg   = (mode == SCAN_INTL) && (in_field != fid_q);
    start     = in_valid && (in_sof || (active_q && fid_chg));
    close     = start && active_q;
    cnt_en    = in_valid && (start || active_q);
    line_base = start ? '0 : line_q;
    lovf_base = start ? 1'b0 : lovf_q;
    line_d    = line_base;
    lovf_d    = lovf_base;
    if (in_eol) begin
      lovf_d = lovf_base | (line_base == CNT_MAX);
      line_d = (line_base == CNT_MAX) ? CNT_MAX : line_base + 1'b1;
    end
    h_sel     = ((mode == SCAN_INTL) && fid_q) ? cfg_height1 : cfg_height0;
    fld_ok    = !line_err && !pix_pend && !lovf_q && (line_q == h_sel);
    active_d  = cfg_chg ? 1'b0 : (start | active_q);
    res_d.ok  = fld_ok;
    res_d.fid = fid_q;
    res_vld_d = close && !cfg_chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      res_vld_q <= 1'b0;
    end else begin
      active_q  <= active_d;
      res_vld_q <= res_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fid_q <= 1'b0;
    end else if (start) begin
      fid_q <= in_field;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      lovf_q <= 1'b0;
    end else if (cnt_en) begin
      line_q <= line_d;
      lovf_q <= lovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (close) begin
      res_q <= res_d;
    end
  end

  assign res_vld = res_vld_q;
  assign res     = res_q;

endmodule

// File: rtl/vrc_match_flag.sv
module vrc_match_flag
  import vrc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cfg_chg,
  input  logic  cfg_interlaced,
  input  logic  res_vld,
  input  fres_t res,
  output logic  match_o
);

  localparam int unsigned N_FLD = 2;

  scan_e            mode;
  logic [N_FLD-1:0] seen_v;
  logic             upd_en;
  logic             match_q;
  logic             match_d;

  assign mode   = scan_e'(cfg_interlaced);
  assign upd_en = cfg_chg | res_vld;

  // Latest verdict per field identifier (interlaced history)
  for (genvar f = 0; f < N_FLD; f++) begin : g_seen
    logic seen_q;
    logic seen_d;

    always_comb begin
      seen_d = seen_q;
      if (cfg_chg) begin
        seen_d = 1'b0;
      end else if (res_vld && (mode == SCAN_INTL) && (res.fid == 1'(f))) begin
        seen_d = res.ok;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_q <= 1'b0;
      end else if (upd_en) begin
        seen_q <= seen_d;
      end
    end

    assign seen_v[f] = seen_q;
  end

  always_comb begin
    match_d = match_q;
    if (cfg_chg) begin
      match_d = 1'b0;
    end else if (res_vld) begin
      if (mode == SCAN_PROG) begin
        match_d = res.ok;
      end else begin
        match_d = res.ok && seen_v[~res.fid];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
    end else if (upd_en) begin
      match_q <= match_d;
    end
  end

  assign match_o = match_q;

endmodule

// File: rtl/vrc_res_check.sv
module vrc_res_check
  import vrc_pkg::*;
#(
  parameter int unsigned DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic             in_field,
  input  logic [DIM_W-1:0] cfg_width,
  input  logic [DIM_W-1:0] cfg_height0,
  input  logic [DIM_W-1:0] cfg_height1,
  input  logic             cfg_interlaced,
  output logic             match_o
);

  logic  cfg_chg;
  logic  start;
  logic  cnt_en;
  logic  pix_pend;
  logic  line_err;
  logic  res_vld;
  fres_t fld_res;

  vrc_cfg_watch #(.DIM_W(DIM_W)) u_cfg (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_width      (cfg_width),
    .cfg_height0    (cfg_height0),
    .cfg_height1    (cfg_height1),
    .cfg_interlaced (cfg_interlaced),
    .cfg_chg        (cfg_chg)
  );

  vrc_line_meter #(.DIM_W(DIM_W)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .start     (start),
    .in_eol    (in_eol),
    .cfg_width (cfg_width),
    .pix_pend  (pix_pend),
    .line_err  (line_err)
  );

  vrc_field_meter #(.DIM_W(DIM_W)) u_field (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_sof         (in_sof),
    .in_eol         (in_eol),
    .in_field       (in_field),
    .cfg_interlaced (cfg_interlaced),
    .cfg_height0    (cfg_height0),
    .cfg_height1    (cfg_height1),
    .cfg_chg        (cfg_chg),
    .pix_pend       (pix_pend),
    .line_err       (line_err),
    .start          (start),
    .cnt_en         (cnt_en),
    .res_vld        (res_vld),
    .res            (fld_res)
  );

  vrc_match_flag u_flag (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_chg        (cfg_chg),
    .cfg_interlaced (cfg_interlaced),
    .res_vld        (res_vld),
    .res            (fld_res),
    .match_o        (match_o)
  );

endmodule

// File: rtl/vrc_res_check_sva.sv
module vrc_res_check_sva (
  input logic clk,
  input logic rst_n,
  input logic cfg_interlaced,
  input logic cfg_chg,
  input logic res_vld,
  input logic res_ok,
  input logic match_o
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_low_chk: assert (match_o == 1'b0);
    end
  end

  // R2
  match_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_o) |-> ($past(res_vld) && $past(res_ok)));

  // R2
  prog_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_ok && !cfg_interlaced) ##1 !cfg_chg |-> match_o);

  // R6
  bad_field_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_ok) |=> !match_o);

  // R7
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !match_o);

endmodule

bind vrc_res_check vrc_res_check_sva u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_interlaced (cfg_interlaced),
  .cfg_chg        (cfg_chg),
  .res_vld        (res_vld),
  .res_ok         (fld_res.ok),
  .match_o        (match_o)
);

// File: tb/tb_vrc_res_check.sv
module tb_vrc_res_check;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_sof, in_eol, in_field;
  logic [DW-1:0] cfg_width, cfg_height0, cfg_height1;
  logic          cfg_interlaced;
  logic          match_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  bit          m_match = 0, m_ok0 = 0, m_ok1 = 0, m_primed = 0;
  bit          m_active = 0, m_fid = 0, m_bad = 0;
  int          m_pix = 0, m_lines = 0;
  bit          m_pend = 0, m_pend_ok = 0, m_pend_fid = 0;
  logic [DW-1:0] p_w = '0, p_h0 = '0, p_h1 = '0;
  bit          p_il = 0;

  vrc_res_check #(.DIM_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eol(in_eol), .in_field(in_field), .cfg_width(cfg_width),
    .cfg_height0(cfg_height0), .cfg_height1(cfg_height1),
    .cfg_interlaced(cfg_interlaced), .match_o(match_o)
  );

  always #2 clk = ~clk;

  // reference model, one step per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_match = 0; m_ok0 = 0; m_ok1 = 0; m_primed = 0; m_active = 0;
      m_pend = 0; m_fid = 0; m_bad = 0; m_pix = 0; m_lines = 0;
    end else begin
      bit cchg;
      cchg = m_primed && (cfg_width != p_w || cfg_height0 != p_h0 ||
                          cfg_height1 != p_h1 || cfg_interlaced != p_il);
      m_primed = 1; p_w = cfg_width; p_h0 = cfg_height0; p_h1 = cfg_height1;
      p_il = cfg_interlaced;
      if (cchg) begin
        m_match = 0; m_ok0 = 0; m_ok1 = 0;
      end else if (m_pend) begin
        if (!cfg_interlaced) m_match = m_pend_ok;
        else if (!m_pend_fid) begin m_ok0 = m_pend_ok; m_match = m_pend_ok && m_ok1; end
        else begin m_ok1 = m_pend_ok; m_match = m_pend_ok && m_ok0; end
      end
      m_pend = 0;
      if (cchg) begin
        m_active = 0;
      end else if (in_valid) begin
        if (in_sof || (m_active && cfg_interlaced && in_field != m_fid)) begin
          if (m_active) begin
            int h;
            h = (cfg_interlaced && m_fid) ? int'(cfg_height1) : int'(cfg_height0);
            m_pend = 1; m_pend_fid = m_fid;
            m_pend_ok = !m_bad && m_pix == 0 && m_lines == h;
          end
          m_active = 1; m_fid = in_field; m_pix = 0; m_lines = 0; m_bad = 0;
        end
        if (m_active) begin
          m_pix++;
          if (in_eol) begin
            if (m_pix != int'(cfg_width)) m_bad = 1;
            m_lines++; m_pix = 0;
          end
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (match_o !== m_match) begin
        n_bad++;
        $display("FAIL %s: match_o=%b expected %b at %0t", cur_req, match_o, m_match, $time);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end

  task automatic drive(bit v, bit s, bit e, bit f);
    @(negedge clk);
    in_valid = v; in_sof = s; in_eol = e; in_field = f;
  endtask

  task automatic idle(int n);
    repeat (n) drive(0, 0, 0, 0);
  endtask

  task automatic check(string tag, bit exp);
    n_cmp++;
    if (match_o !== exp) begin
      n_bad++;
      $display("FAIL %s: match_o=%b expected %b at %0t", tag, match_o, exp, $time);
    end
  endtask

  // One field: nl lines of w pixels (line 1 has w1), optional unfinished tail.
  // After its first beat, checks the verdict of the field that beat closed.
  task automatic sq(int nl, int w, int w1, bit fld, bit sof, int tail,
                    string tag, bit exp);
    cur_req = tag;
    for (int l = 0; l < nl; l++) begin
      int lw;
      lw = (l == 1) ? w1 : w;
      for (int p = 0; p < lw; p++) begin
        drive(1, sof && l == 0 && p == 0, p == lw - 1, fld);
        if (l == 0 && p == 0) begin
          idle(2);
          check(tag, exp);
        end
      end
    end
    for (int t = 0; t < tail; t++) drive(1, 0, 0, fld);
    idle(1);
  endtask

  task automatic set_cfg(int w, int h0, int h1, bit il);
    @(negedge clk);
    cfg_width = DW'(w); cfg_height0 = DW'(h0); cfg_height1 = DW'(h1);
    cfg_interlaced = il;
    idle(2);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 0; in_sof = 0; in_eol = 0; in_field = 0;
    cfg_width = 16'd4; cfg_height0 = 16'd3; cfg_height1 = 16'd2; cfg_interlaced = 0;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    idle(3);
    check("R1", 1'b0);

    // progressive
    sq(3, 4, 4, 0, 1, 0, "R1", 0);
    sq(3, 4, 4, 1, 1, 0, "R2", 1);
    sq(3, 4, 3, 0, 1, 0, "R2", 1);   // previous had field id 1: ignored
    sq(3, 4, 4, 0, 1, 0, "R3", 0);   // short middle line
    sq(3, 4, 5, 0, 1, 0, "R2", 1);
    sq(4, 4, 4, 0, 1, 0, "R3", 0);   // long middle line
    sq(3, 4, 4, 0, 1, 2, "R4", 0);   // four lines
    sq(2, 4, 4, 0, 1, 0, "R4", 0);   // unfinished tail
    sq(3, 4, 4, 0, 1, 0, "R4", 0);   // two lines
    sq(3, 4, 4, 1, 0, 0, "R5", 0);   // id toggle without sof is no boundary
    sq(3, 4, 4, 0, 1, 0, "R5", 0);   // merged six-line field
    sq(3, 4, 4, 0, 1, 0, "R2", 1);

    // configuration change mid-field
    @(negedge clk); cfg_width = 16'd5;
    idle(2);
    check("R7", 1'b0);
    sq(3, 5, 5, 0, 0, 0, "R7", 0);   // beats without sof: ignored
    sq(3, 5, 5, 0, 1, 0, "R7", 0);
    sq(3, 5, 5, 0, 1, 0, "R7", 1);

    // interlaced
    set_cfg(4, 3, 2, 1);
    check("R7", 1'b0);
    sq(3, 4, 4, 0, 1, 0, "R6", 0);
    sq(2, 4, 4, 1, 0, 0, "R6", 0);   // id change closes field 0, field 1 unseen
    sq(3, 4, 4, 0, 1, 0, "R6", 1);
    sq(2, 4, 4, 1, 0, 0, "R6", 1);
    sq(3, 4, 5, 0, 1, 0, "R6", 1);   // this field 0 is bad
    sq(2, 4, 4, 1, 0, 0, "R6", 0);
    sq(3, 4, 4, 0, 1, 0, "R6", 0);   // good field 1, field 0 still bad
    sq(3, 4, 4, 1, 0, 0, "R6", 1);   // field 1 given height0 lines
    sq(3, 4, 4, 0, 1, 0, "R6", 0);
    sq(2, 4, 4, 1, 0, 0, "R6", 0);
    sq(3, 4, 4, 0, 1, 0, "R6", 1);

    // saturation
    set_cfg(1, 1, 1, 0);
    sq(1, 1, 1, 0, 1, 0, "R8", 0);
    sq(1, 1, 1, 0, 1, 0, "R8", 1);
    cur_req = "R8";
    drive(1, 1, 0, 0);
    for (int i = 0; i < 65535; i++) drive(1, 0, 0, 0);
    drive(1, 0, 1, 0);               // 65537-pixel line
    idle(1);
    sq(1, 1, 1, 0, 1, 0, "R8", 0);
    sq(1, 1, 1, 0, 1, 0, "R8", 1);
    idle(4);
    finish_run();
  end

endmodule